// File: doc/BRIEF.md
# Serial flash erase command decoder

This block sits behind the command front end of a 256-Mbit serial NOR flash. It takes an erase request that has already been decoded into an erase size code and a 24-bit host address. It joins that address to a one-bit bank register, which gives hosts limited to 24-bit addressing a way to reach the upper 16 MB. It then decides whether the request is legal. A legal request produces an aligned start and end byte address for the array sequencer. An illegal request produces an error flag, and no range is issued.

Legality depends on three things. The first is a strap that selects the sector layout: either thirty-two 4 KB parameter sectors alongside 64 KB uniform sectors, or 256 KB uniform sectors. The second is a configuration bit that places the parameter sectors at the top or the bottom of the array. The third is the erase size itself. The configuration register has a freeze bit that can only be set. Once it is set, the placement bit, the protection-side bit, the one-time-programmable write enable and the block-protect field all stop accepting writes until reset. The bank register is written by the command that older parts used for power-down.

Top module: `fe_erase_decoder`

## Requirements
- R1: `req_kind` codes are 0 = 4 KB, 1 = 8 KB, 2 = 64 KB and 3 = 256 KB. A request with code 1 is always rejected.
- R2: A 4 KB erase is accepted only inside the 128 KB parameter area. When `cr_q[2]` is 0, this area is where effective address bits [24:17] are all zero. When `cr_q[2]` is 1, it is where those bits are all one.
- R3: A 64 KB erase is accepted when `arch_256k` is 0 at any address, including the parameter area, and is rejected when `arch_256k` is 1.
- R4: A 256 KB erase is accepted when `arch_256k` is 1 and is rejected when it is 0.
- R5: The effective address is `{bank_q, req_addr}`. For an accepted request, `rng_start` is that address aligned down to the erase size, and `rng_end` is `rng_start + size - 1`.
- R6: One cycle after `req_valid`, `done` pulses for exactly one cycle. On acceptance, `rng_valid` is 1 and `err` is 0. On rejection, `err` is 1 and `rng_valid` is 0.
- R7: Writing 1 to `cr_q[0]` (freeze) sets it. Writing 0 to it has no effect, and only reset clears it.
- R8: While freeze is set, writes to `cr_q[2]` (parameter placement), `cr_q[3]` (one-time-programmable write enable), `cr_q[5]` (protection side) and to `bp_q` are ignored. The other configuration bits still take writes. A write that sets freeze still updates the locked bits in that same write.
- R9: A bank write stores only the low bit of `bank_wdata`. Freeze does not affect bank writes.
- R10: After reset, `cr_q`, `bp_q`, `bank_q`, `done`, `err` and `rng_valid` are all 0.
- R11: A request in the same cycle as a bank or configuration write is decoded with the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arch_256k | input | 1 | Sector layout strap: 0 = parameter sectors plus 64 KB sectors, 1 = 256 KB uniform sectors |
| cr_we | input | 1 | Configuration register write strobe |
| cr_wdata | input | 8 | Configuration write data |
| bp_we | input | 1 | Block-protect field write strobe |
| bp_wdata | input | 3 | Block-protect write data |
| bank_we | input | 1 | Bank register write strobe |
| bank_wdata | input | 8 | Bank write data |
| req_valid | input | 1 | Erase request strobe |
| req_kind | input | 2 | Erase size code |
| req_addr | input | 24 | Host byte address |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected |
| rng_valid | output | 1 | Range issued |
| rng_start | output | 25 | First byte of the erase range |
| rng_end | output | 25 | Last byte of the erase range |
| cr_q | output | 8 | Configuration register |
| bp_q | output | 3 | Block-protect field |
| bank_q | output | 1 | Bank register (address bit 24) |

## Verification
Every erase size is tried under both layout straps, so that an accept decision which depends only on the size code is told apart from one that depends on the strap. 4 KB requests are placed on the first and last sectors of the parameter area and one byte outside it, for both placements. This exposes an off-by-one in the region bound and a swapped top/bottom sense. The same 24-bit address is sent with the bank bit at 0 and at 1, and 256 KB and 64 KB ranges are taken on both sides of the 16 MB line, which shows whether bit 24 reaches both the region test and the output range. Configuration writes are issued before, during and after the freeze, with values that touch the locked and unlocked bits together, so that a lock mask applied to the wrong bits shows up.

// File: rtl/fe_pkg.sv
package fe_pkg;

   // Erase size codes as seen on req_kind
   typedef enum logic [1:0] {
      ERS_4K   = 2'd0,
      ERS_8K   = 2'd1,
      ERS_64K  = 2'd2,
      ERS_256K = 2'd3
   } ers_kind_e;

   // Configuration register field positions
   localparam int CR_FRZ  = 0;
   localparam int CR_PTOP = 2;
   localparam int CR_OTP  = 3;
   localparam int CR_PROT = 5;

   // Bits held by the freeze once it is set
   localparam logic [7:0] CR_LOCK_DEFAULT = 8'b0010_1100;

endpackage

// File: rtl/fe_cfg_regs.sv
module fe_cfg_regs #(
   parameter int          CR_W      = 8,
   parameter int          BP_W      = 3,
   parameter int          FRZ_BIT   = 0,
   parameter logic [CR_W-1:0] LOCK_MASK = CR_W'(fe_pkg::CR_LOCK_DEFAULT)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cr_we,
   input  logic [CR_W-1:0] cr_wdata,
   input  logic            bp_we,
   input  logic [BP_W-1:0] bp_wdata,
   output logic [CR_W-1:0] cr_q,
   output logic [BP_W-1:0] bp_q
);

   if (FRZ_BIT >= CR_W) begin : g_bad_frz
      $error("fe_cfg_regs: freeze bit outside register");
   end
   if (LOCK_MASK[FRZ_BIT]) begin : g_bad_mask
      $error("fe_cfg_regs: freeze bit may not be in lock mask");
   end

   logic frozen;
   assign frozen = cr_q[FRZ_BIT];

   // One flop per configuration bit; the kind of bit picks its write rule
   for (genvar b = 0; b < CR_W; b++) begin : g_bit
      logic q;
      if (b == FRZ_BIT) begin : g_frz
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= 1'b0;
            else if (cr_we && cr_wdata[b])
               q <= 1'b1;
         end
      end else if (LOCK_MASK[b]) begin : g_lock
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= 1'b0;
            else if (cr_we && !frozen)
               q <= cr_wdata[b];
         end
      end else begin : g_free
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= 1'b0;
            else if (cr_we)
               q <= cr_wdata[b];
         end
      end
      assign cr_q[b] = q;
   end

   // Block-protect field follows the same lock as the masked bits
   always_ff @(posedge clk) begin
      if (!rst_n)
         bp_q <= '0;
      else if (bp_we && !frozen)
         bp_q <= bp_wdata;
   end

endmodule

// File: rtl/fe_bank_reg.sv
module fe_bank_reg #(
   parameter int BANK_W = 1,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [BANK_W-1:0] q
);

   if (BANK_W < 1 || BANK_W > DATA_W) begin : g_bad_w
      $error("fe_bank_reg: bank width must fit the write data");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (we)
         q <= wdata[BANK_W-1:0];
   end

endmodule

// File: rtl/fe_range_chk.sv
module fe_range_chk
   import fe_pkg::*;
#(
   parameter int ADDR_W        = 25,
   parameter int SEC4_LG       = 12,
   parameter int SEC64_LG      = 16,
   parameter int SEC256_LG     = 18,
   parameter int PARAM_SECTORS = 32
) (
   input  logic [1:0]        kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic              param_top,
   input  logic              arch_256k,
   output logic              legal,
   output logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] end_addr
);

   localparam int PARAM_LG = SEC4_LG + $clog2(PARAM_SECTORS);
   localparam int HI_W     = ADDR_W - PARAM_LG;
   localparam logic [ADDR_W-1:0] MASK4   = (ADDR_W'(1) << SEC4_LG) - ADDR_W'(1);
   localparam logic [ADDR_W-1:0] MASK64  = (ADDR_W'(1) << SEC64_LG) - ADDR_W'(1);
   localparam logic [ADDR_W-1:0] MASK256 = (ADDR_W'(1) << SEC256_LG) - ADDR_W'(1);

   if (!(SEC4_LG < SEC64_LG && SEC64_LG < SEC256_LG && SEC256_LG < ADDR_W)) begin : g_bad_sizes
      $error("fe_range_chk: sector sizes must grow and fit the address");
   end
   if (PARAM_LG >= ADDR_W || (1 << $clog2(PARAM_SECTORS)) != PARAM_SECTORS) begin : g_bad_param
      $error("fe_range_chk: parameter area must be a power of two inside the array");
   end

   logic [HI_W-1:0]   hi;
   logic              in_param;
   logic [ADDR_W-1:0] mask;
   ers_kind_e         k;

   assign hi       = addr[ADDR_W-1:PARAM_LG];
   assign in_param = param_top ? (&hi) : ~(|hi);
   assign k        = ers_kind_e'(kind);

   always_comb begin
      legal = 1'b0;
      mask  = MASK4;
      case (k)
         ERS_4K: begin
            legal = in_param;
            mask  = MASK4;
         end
         ERS_8K: begin
            legal = 1'b0;
            mask  = MASK4;
         end
         ERS_64K: begin
            legal = !arch_256k;
            mask  = MASK64;
         end
         ERS_256K: begin
            legal = arch_256k;
            mask  = MASK256;
         end
         default: begin
            legal = 1'b0;
            mask  = MASK4;
         end
      endcase
   end

   assign start_addr = addr & ~mask;
   assign end_addr   = addr | mask;

endmodule

// File: rtl/fe_erase_decoder.sv
module fe_erase_decoder
   import fe_pkg::*;
#(
   parameter int ADDR_W        = 25,
   parameter int HOST_W        = 24,
   parameter int CR_W          = 8,
   parameter int BP_W          = 3,
   parameter int BANK_DATA_W   = 8,
   parameter int SEC4_LG       = 12,
   parameter int SEC64_LG      = 16,
   parameter int SEC256_LG     = 18,
   parameter int PARAM_SECTORS = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     arch_256k,
   input  logic                     cr_we,
   input  logic [CR_W-1:0]          cr_wdata,
   input  logic                     bp_we,
   input  logic [BP_W-1:0]          bp_wdata,
   input  logic                     bank_we,
   input  logic [BANK_DATA_W-1:0]   bank_wdata,
   input  logic                     req_valid,
   input  logic [1:0]               req_kind,
   input  logic [HOST_W-1:0]        req_addr,
   output logic                     done,
   output logic                     err,
   output logic                     rng_valid,
   output logic [ADDR_W-1:0]        rng_start,
   output logic [ADDR_W-1:0]        rng_end,
   output logic [CR_W-1:0]          cr_q,
   output logic [BP_W-1:0]          bp_q,
   output logic [ADDR_W-HOST_W-1:0] bank_q
);

   localparam int BANK_W = ADDR_W - HOST_W;

   if (BANK_W < 1) begin : g_bad_bank
      $error("fe_erase_decoder: array must be wider than the host address");
   end
   if (CR_W <= CR_PROT) begin : g_bad_cr
      $error("fe_erase_decoder: configuration register too narrow for its fields");
   end

   logic [ADDR_W-1:0] eff_addr;
   logic              legal;
   logic [ADDR_W-1:0] s_addr;
   logic [ADDR_W-1:0] e_addr;

   fe_cfg_regs #(
      .CR_W      (CR_W),
      .BP_W      (BP_W),
      .FRZ_BIT   (CR_FRZ),
      .LOCK_MASK (CR_W'(CR_LOCK_DEFAULT))
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cr_we    (cr_we),
      .cr_wdata (cr_wdata),
      .bp_we    (bp_we),
      .bp_wdata (bp_wdata),
      .cr_q     (cr_q),
      .bp_q     (bp_q)
   );

   fe_bank_reg #(
      .BANK_W (BANK_W),
      .DATA_W (BANK_DATA_W)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we),
      .wdata (bank_wdata),
      .q     (bank_q)
   );

   assign eff_addr = {bank_q, req_addr};

   fe_range_chk #(
      .ADDR_W        (ADDR_W),
      .SEC4_LG       (SEC4_LG),
      .SEC64_LG      (SEC64_LG),
      .SEC256_LG     (SEC256_LG),
      .PARAM_SECTORS (PARAM_SECTORS)
   ) u_range (
      .kind       (req_kind),
      .addr       (eff_addr),
      .param_top  (cr_q[CR_PTOP]),
      .arch_256k  (arch_256k),
      .legal      (legal),
      .start_addr (s_addr),
      .end_addr   (e_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done      <= 1'b0;
         err       <= 1'b0;
         rng_valid <= 1'b0;
         rng_start <= '0;
         rng_end   <= '0;
      end else begin
         done      <= req_valid;
         err       <= req_valid && !legal;
         rng_valid <= req_valid && legal;
         if (req_valid && legal) begin
            rng_start <= s_addr;
            rng_end   <= e_addr;
         end
      end
   end

endmodule

// File: rtl/fe_erase_decoder_chk.sv
module fe_erase_decoder_chk #(
   parameter int ADDR_W    = 25,
   parameter int HOST_W    = 24,
   parameter int CR_W      = 8,
   parameter int BP_W      = 3,
   parameter int SEC4_LG   = 12,
   parameter int SEC64_LG  = 16,
   parameter int SEC256_LG = 18
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     arch_256k,
   input logic                     req_valid,
   input logic [1:0]               req_kind,
   input logic                     bank_we,
   input logic                     done,
   input logic                     err,
   input logic                     rng_valid,
   input logic [ADDR_W-1:0]        rng_start,
   input logic [ADDR_W-1:0]        rng_end,
   input logic [CR_W-1:0]          cr_q,
   input logic [BP_W-1:0]          bp_q,
   input logic [ADDR_W-HOST_W-1:0] bank_q
);

   localparam logic [ADDR_W-1:0] SPAN4   = (ADDR_W'(1) << SEC4_LG) - ADDR_W'(1);
   localparam logic [ADDR_W-1:0] SPAN64  = (ADDR_W'(1) << SEC64_LG) - ADDR_W'(1);
   localparam logic [ADDR_W-1:0] SPAN256 = (ADDR_W'(1) << SEC256_LG) - ADDR_W'(1);

   // R6
   done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> done);

   // R6
   no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !done);

   // R6
   outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (err != rng_valid));

   // R6
   outcome_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err || rng_valid) |-> done);

   // R1
   no_8k_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd1) |=> err);

   // R3
   k64_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd2 && arch_256k) |=> err);

   // R4
   k256_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd3 && !arch_256k) |=> err);

   // R5
   range_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rng_valid |-> ((rng_end - rng_start) == SPAN4 ||
                     (rng_end - rng_start) == SPAN64 ||
                     (rng_end - rng_start) == SPAN256));

   // R5
   range_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rng_valid |-> ((rng_start & SPAN4) == '0));

   // R7
   freeze_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cr_q[0] |=> cr_q[0]);

   // R8
   frozen_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cr_q[0] |=> ($stable(cr_q[2]) && $stable(cr_q[3]) && $stable(cr_q[5]) && $stable(bp_q)));

   // R9
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_we |=> $stable(bank_q));

endmodule

bind fe_erase_decoder fe_erase_decoder_chk #(
   .ADDR_W    (ADDR_W),
   .HOST_W    (HOST_W),
   .CR_W      (CR_W),
   .BP_W      (BP_W),
   .SEC4_LG   (SEC4_LG),
   .SEC64_LG  (SEC64_LG),
   .SEC256_LG (SEC256_LG)
) u_fe_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .arch_256k (arch_256k),
   .req_valid (req_valid),
   .req_kind  (req_kind),
   .bank_we   (bank_we),
   .done      (done),
   .err       (err),
   .rng_valid (rng_valid),
   .rng_start (rng_start),
   .rng_end   (rng_end),
   .cr_q      (cr_q),
   .bp_q      (bp_q),
   .bank_q    (bank_q)
);

// File: tb/test_fe_erase_decoder.sv
`timescale 1ns/1ps
module test_fe_erase_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arch_256k = 1'b0;
   logic        cr_we = 1'b0;
   logic [7:0]  cr_wdata = '0;
   logic        bp_we = 1'b0;
   logic [2:0]  bp_wdata = '0;
   logic        bank_we = 1'b0;
   logic [7:0]  bank_wdata = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [23:0] req_addr = '0;
   logic        done, err, rng_valid;
   logic [24:0] rng_start, rng_end;
   logic [7:0]  cr_q;
   logic [2:0]  bp_q;
   logic [0:0]  bank_q;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fe_erase_decoder i_fe_erase_decoder (
      .clk(clk), .rst_n(rst_n), .arch_256k(arch_256k),
      .cr_we(cr_we), .cr_wdata(cr_wdata), .bp_we(bp_we), .bp_wdata(bp_wdata),
      .bank_we(bank_we), .bank_wdata(bank_wdata),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .done(done), .err(err), .rng_valid(rng_valid),
      .rng_start(rng_start), .rng_end(rng_end),
      .cr_q(cr_q), .bp_q(bp_q), .bank_q(bank_q));

   // {arch, top, bank, kind, addr24, ok, start25}
   localparam int NV = 19;
   localparam logic [54:0] VEC [0:NV-1] = '{
      {1'b0, 1'b0, 1'b0, 2'd0, 24'h001234, 1'b1, 25'h0001000},
      {1'b0, 1'b0, 1'b0, 2'd0, 24'h01FFFF, 1'b1, 25'h001F000},
      {1'b0, 1'b0, 1'b0, 2'd0, 24'h020000, 1'b0, 25'h0000000},
      {1'b0, 1'b0, 1'b1, 2'd0, 24'h001234, 1'b0, 25'h0000000},
      {1'b0, 1'b1, 1'b1, 2'd0, 24'hFE0000, 1'b1, 25'h1FE0000},
      {1'b0, 1'b1, 1'b1, 2'd0, 24'hFDFFFF, 1'b0, 25'h0000000},
      {1'b0, 1'b1, 1'b0, 2'd0, 24'h001000, 1'b0, 25'h0000000},
      {1'b0, 1'b0, 1'b0, 2'd1, 24'h000000, 1'b0, 25'h0000000},
      {1'b1, 1'b0, 1'b0, 2'd1, 24'h000000, 1'b0, 25'h0000000},
      {1'b0, 1'b0, 1'b0, 2'd2, 24'h00ABCD, 1'b1, 25'h0000000},
      {1'b0, 1'b0, 1'b1, 2'd2, 24'hFFFFFF, 1'b1, 25'h1FF0000},
      {1'b1, 1'b0, 1'b0, 2'd2, 24'h123456, 1'b0, 25'h0000000},
      {1'b0, 1'b0, 1'b0, 2'd3, 24'h123456, 1'b0, 25'h0000000},
      {1'b1, 1'b0, 1'b0, 2'd3, 24'h123456, 1'b1, 25'h0100000},
      {1'b1, 1'b0, 1'b1, 2'd3, 24'hFFFFFF, 1'b1, 25'h1FC0000},
      {1'b1, 1'b0, 1'b1, 2'd3, 24'h000000, 1'b1, 25'h1000000},
      {1'b0, 1'b0, 1'b0, 2'd2, 24'hFFFFFF, 1'b1, 25'h0FF0000},
      {1'b1, 1'b1, 1'b0, 2'd0, 24'h000000, 1'b0, 25'h0000000},
      {1'b1, 1'b0, 1'b0, 2'd0, 24'h002000, 1'b1, 25'h0002000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [24:0] span(input logic [1:0] kind);
      case (kind)
         2'd2:    return 25'h000FFFF;
         2'd3:    return 25'h003FFFF;
         default: return 25'h0000FFF;
      endcase
   endfunction

   function automatic string kind_req(input logic [1:0] kind);
      case (kind)
         2'd0:    return "R2";
         2'd1:    return "R1";
         2'd2:    return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic cfg_write(input logic [7:0] d);
      @(negedge clk); cr_we = 1'b1; cr_wdata = d;
      @(negedge clk); cr_we = 1'b0;
   endtask

   task automatic bp_write(input logic [2:0] d);
      @(negedge clk); bp_we = 1'b1; bp_wdata = d;
      @(negedge clk); bp_we = 1'b0;
   endtask

   task automatic bank_write(input logic [7:0] d);
      @(negedge clk); bank_we = 1'b1; bank_wdata = d;
      @(negedge clk); bank_we = 1'b0;
   endtask

   task automatic run_req(input logic [1:0] kind, input logic [23:0] addr,
                          input logic ok, input logic [24:0] st);
      @(negedge clk); req_valid = 1'b1; req_kind = kind; req_addr = addr;
      @(negedge clk); req_valid = 1'b0;
      check("R6 done", 32'(done), 32'd1);
      check(kind_req(kind), 32'(rng_valid), 32'(ok));
      check(kind_req(kind), 32'(err), 32'(!ok));
      if (ok) begin
         check("R5 start", 32'(rng_start), 32'(st));
         check("R5 end", 32'(rng_end), 32'(st + span(kind)));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset values
      check("R10 cr", 32'(cr_q), 32'h0);
      check("R10 bp", 32'(bp_q), 32'h0);
      check("R10 bank", 32'(bank_q), 32'h0);
      check("R10 done", 32'(done), 32'h0);
      check("R10 err", 32'(err), 32'h0);
      check("R10 valid", 32'(rng_valid), 32'h0);

      // Table walk: layout, placement, bank, size
      for (int i = 0; i < NV; i++) begin
         arch_256k = VEC[i][54];
         cfg_write({5'b0, VEC[i][53], 2'b0});
         bank_write({7'b0, VEC[i][52]});
         run_req(VEC[i][51:50], VEC[i][49:26], VEC[i][25], VEC[i][24:0]);
      end

      // R6 pulse lasts one cycle
      @(negedge clk);
      check("R6 pulse", 32'(done), 32'd0);
      check("R6 err drop", 32'(err), 32'd0);

      // R9 only low bit stored
      bank_write(8'hFE);
      check("R9 bank upper", 32'(bank_q), 32'd0);
      bank_write(8'hFF);
      check("R9 bank low", 32'(bank_q), 32'd1);

      // R11 request decoded with bank value before the same-cycle write
      arch_256k = 1'b0;
      @(negedge clk);
      bank_we = 1'b1; bank_wdata = 8'h00;
      req_valid = 1'b1; req_kind = 2'd2; req_addr = 24'hFFFFFF;
      @(negedge clk);
      bank_we = 1'b0; req_valid = 1'b0;
      check("R11 start", 32'(rng_start), 32'h1FF0000);
      check("R11 bank", 32'(bank_q), 32'd0);

      // R7/R8 freeze
      cfg_write(8'h00);
      bp_write(3'b101);
      check("R8 bp open", 32'(bp_q), 32'd5);
      cfg_write(8'h2D);
      check("R8 same write", 32'(cr_q), 32'h2D);
      cfg_write(8'h52);
      check("R8 frozen cr", 32'(cr_q), 32'h7F);
      check("R7 freeze kept", 32'(cr_q[0]), 32'd1);
      bp_write(3'b000);
      check("R8 bp frozen", 32'(bp_q), 32'd5);
      bank_write(8'h01);
      check("R9 bank frozen", 32'(bank_q), 32'd1);
      // R8 placement stays top: 4 KB at array bottom rejected
      bank_write(8'h00);
      run_req(2'd0, 24'h000000, 1'b0, 25'h0);
      run_req(2'd0, 24'hFFF000, 1'b0, 25'h0);
      bank_write(8'h01);
      run_req(2'd0, 24'hFFF000, 1'b1, 25'h1FFF000);

      // R7 reset clears freeze
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R7 reset clears", 32'(cr_q), 32'h0);
      cfg_write(8'h04);
      check("R7 writable again", 32'(cr_q), 32'h04);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule